// File: doc/BRIEF.md
# Sticky Interrupt Status and Mask Block

This block watches a small set of live condition inputs: system initialising, loss of lock on PLL B, loss of lock on PLL A and loss of input signal. It captures each one in a sticky bit that software can inspect later. A mask register decides which captured conditions may drive the shared active-low interrupt pin. The condition inputs may come from other clock domains, so they are first passed through a parameterised synchronizer.

Software reaches three registers through a plain single-cycle register port: the live (synchronized) status, the sticky flags and the mask. A sticky flag is cleared by writing 0 to its bit. Writing 1 to it leaves it alone. A condition that is still asserted wins over a clearing write in the same cycle. The interrupt output is registered, so it changes on the same clock edge as the register state that causes it.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After reset the sticky and mask registers read 0 and irq_n_o is high.
- R2: The register select is addr_i: 0 = live status, 1 = sticky, 2 = mask, 3 = reserved. Bit positions in all three registers are: bit 3 system initialising, bit 2 PLL B unlocked, bit 1 PLL A unlocked, bit 0 input signal lost.
- R3: A condition input level shows in the live status register SYNC_STAGES clock edges after it is sampled.
- R4: A sticky bit sets on the edge after its live status bit is high, and stays set after the condition drops.
- R5: Writing 0 to a sticky bit clears it at that write edge.
- R6: Writing 1 to a sticky bit leaves it unchanged.
- R7: If a live status bit is high in the cycle of a clearing write, that sticky bit stays set.
- R8: irq_n_o is low exactly when some sticky bit is set and its mask bit is 0. It updates on the same edge as the sticky or mask change.
- R9: The mask register is written at address 2 and reads back the written value. A mask bit of 1 stops its condition from pulling irq_n_o low.
- R10: Writes to address 0 or 3 change no state, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_i | input | NUM_COND | Live condition inputs, asynchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for reads and writes |
| wr_data_i | input | NUM_COND | Write data |
| rd_data_o | output | NUM_COND | Read data of the selected register (combinational) |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
The bench targets the collision of a clearing write with a condition that is still asserted. A design that lets the write win would lose an event and release the interrupt too early. It checks that writing 1 preserves a flag, since a design with clear-on-1 semantics would wipe the flags instead. A one-cycle condition pulse must still be captured after the synchronizer latency, which a mis-counted synchronizer would drop or show at the wrong cycle. Masking and unmasking a pending flag must move irq_n_o on the very edge of the mask write. Stray writes to the status and reserved addresses must not disturb the mask or the sticky flags.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_LIVE   = 2'd0,
    SEL_STICKY = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/stat_irq_sync.sv
module stat_irq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage_q;
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '0;
          else if (s == 0) stage_q[s] <= d_i;
          else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/stat_irq_sticky.sv
module stat_irq_sticky #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] live_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] sticky_d_o,
  output logic [WIDTH-1:0] sticky_q_o
);
  logic [WIDTH-1:0] sticky_q;

  // zero in write data clears; live level always wins
  always_comb begin
    sticky_d_o = sticky_q;
    if (wr_i) sticky_d_o = sticky_q & wr_data_i;
    sticky_d_o = sticky_d_o | live_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else sticky_q <= sticky_d_o;
  end

  assign sticky_q_o = sticky_q;
endmodule

// File: rtl/stat_irq_mask.sv
module stat_irq_mask #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] mask_d_o,
  output logic [WIDTH-1:0] mask_q_o
);
  logic [WIDTH-1:0] mask_q;

  assign mask_d_o = wr_i ? wr_data_i : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else mask_q <= mask_d_o;
  end

  assign mask_q_o = mask_q;
endmodule

// File: rtl/stat_irq_out.sv
module stat_irq_out #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sticky_d_i,
  input  logic [WIDTH-1:0] mask_d_i,
  output logic             irq_n_o
);
  logic irq_n_q;

  // registered from next-state so the pin is glitch-free and aligned with the flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_n_q <= 1'b1;
    else irq_n_q <= ~(|(sticky_d_i & ~mask_d_i));
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
#(
  parameter int unsigned NUM_COND    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_COND-1:0] wr_data_i,
  output logic [NUM_COND-1:0] rd_data_o,
  output logic                irq_n_o
);
  logic [NUM_COND-1:0] live_q;
  logic [NUM_COND-1:0] sticky_d, sticky_q;
  logic [NUM_COND-1:0] mask_d, mask_q;
  logic                wr_sticky, wr_mask;
  reg_sel_e            sel;

  assign sel       = reg_sel_e'(addr_i);
  assign wr_sticky = wr_en_i && (sel == SEL_STICKY);
  assign wr_mask   = wr_en_i && (sel == SEL_MASK);

  stat_irq_sync #(.WIDTH(NUM_COND), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cond_i),
    .q_o   (live_q)
  );

  stat_irq_sticky #(.WIDTH(NUM_COND)) sticky_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .live_i    (live_q),
    .wr_i      (wr_sticky),
    .wr_data_i (wr_data_i),
    .sticky_d_o(sticky_d),
    .sticky_q_o(sticky_q)
  );

  stat_irq_mask #(.WIDTH(NUM_COND)) mask_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_mask),
    .wr_data_i(wr_data_i),
    .mask_d_o (mask_d),
    .mask_q_o (mask_q)
  );

  stat_irq_out #(.WIDTH(NUM_COND)) out_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sticky_d_i(sticky_d),
    .mask_d_i  (mask_d),
    .irq_n_o   (irq_n_o)
  );

  always_comb begin
    unique case (sel)
      SEL_LIVE:   rd_data_o = live_q;
      SEL_STICKY: rd_data_o = sticky_q;
      SEL_MASK:   rd_data_o = mask_q;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/stat_irq_ctrl_chk.sv
module stat_irq_ctrl_chk
  import stat_irq_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      wr_data_i,
  input logic [N-1:0]      live_q,
  input logic [N-1:0]      sticky_q,
  input logic [N-1:0]      mask_q,
  input logic              irq_n_o
);
  // R4
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == SEL_STICKY) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  // R6
  sticky_keep_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == SEL_STICKY) |=>
      ((sticky_q & $past(sticky_q & wr_data_i)) == $past(sticky_q & wr_data_i)));

  // R7
  live_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |live_q |=> ((sticky_q & $past(live_q)) == $past(live_q)));

  // R8
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_n_o == !(|(sticky_q & ~mask_q)));

  // R9
  mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == SEL_MASK) |=> (mask_q == $past(wr_data_i)));

  // R10
  stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == SEL_LIVE || addr_i == SEL_RSVD)) |=> $stable(mask_q));
endmodule

bind stat_irq_ctrl stat_irq_ctrl_chk #(.N(NUM_COND)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wr_data_i(wr_data_i),
  .live_q   (live_q),
  .sticky_q (sticky_q),
  .mask_q   (mask_q),
  .irq_n_o  (irq_n_o)
);

// File: tb/stat_irq_ctrl_tb_top.sv
module stat_irq_ctrl_tb_top;
  localparam int unsigned N    = 4;
  localparam int unsigned SYNC = 2;
  localparam logic [1:0] A_LIVE = 2'd0, A_STK = 2'd1, A_MSK = 2'd2, A_RSV = 2'd3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] cond_i = '0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   addr_i = '0;
  logic [N-1:0] wr_data_i = '0;
  logic [N-1:0] rd_data_o;
  logic         irq_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  stat_irq_ctrl #(.NUM_COND(N), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(cond_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_n_o(irq_n_o)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [N-1:0] exp);
    addr_i = a;
    #2;
    chk(req, 32'(rd_data_o), 32'(exp));
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    step();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 sticky", A_STK, '0);
    rd_chk("R1 mask", A_MSK, '0);
    chk("R1 irq", 32'(irq_n_o), 32'd1);
  endtask

  task automatic t_pulse_capture();
    cond_i = 4'b0010;                 // PLL A unlock, bit 1 (R2)
    step();
    cond_i = '0;
    step(SYNC - 1);
    rd_chk("R3 live visible", A_LIVE, 4'b0010);
    rd_chk("R4 not yet sticky", A_STK, 4'b0000);
    step();
    rd_chk("R4 sticky set", A_STK, 4'b0010);
    chk("R8 irq low", 32'(irq_n_o), 32'd0);
    step(3);
    rd_chk("R3 live dropped", A_LIVE, 4'b0000);
    rd_chk("R4 sticky holds", A_STK, 4'b0010);
  endtask

  task automatic t_write_one();
    wr(A_STK, 4'b1111);
    rd_chk("R6 write 1 keeps", A_STK, 4'b0010);
    chk("R6 irq still low", 32'(irq_n_o), 32'd0);
  endtask

  task automatic t_clear();
    wr(A_STK, 4'b1101);
    rd_chk("R5 cleared", A_STK, 4'b0000);
    chk("R8 irq released", 32'(irq_n_o), 32'd1);
  endtask

  task automatic t_live_wins();
    cond_i = 4'b1000;                 // system initialising, bit 3
    step(SYNC + 1);
    rd_chk("R2 init bit", A_STK, 4'b1000);
    wr(A_STK, 4'b0000);
    rd_chk("R7 live wins", A_STK, 4'b1000);
    chk("R7 irq low", 32'(irq_n_o), 32'd0);
    cond_i = '0;
    step(SYNC + 1);
    wr(A_STK, 4'b0000);
    rd_chk("R5 clear after drop", A_STK, 4'b0000);
  endtask

  task automatic t_mask();
    wr(A_MSK, 4'b0001);
    rd_chk("R9 mask readback", A_MSK, 4'b0001);
    cond_i = 4'b0001;                 // input signal lost, bit 0
    step(SYNC + 1);
    cond_i = '0;
    rd_chk("R4 los sticky", A_STK, 4'b0001);
    chk("R9 masked irq high", 32'(irq_n_o), 32'd1);
    wr(A_MSK, 4'b0000);
    chk("R8 unmask irq low", 32'(irq_n_o), 32'd0);
    wr(A_MSK, 4'b1111);
    chk("R8 remask irq high", 32'(irq_n_o), 32'd1);
    step(SYNC);
    wr(A_STK, 4'b0000);
    wr(A_MSK, 4'b0000);
    chk("R8 irq high all clear", 32'(irq_n_o), 32'd1);
  endtask

  task automatic t_stray();
    cond_i = 4'b0100;                 // PLL B unlock, bit 2
    step(SYNC + 1);
    cond_i = '0;
    step(SYNC);
    wr(A_MSK, 4'b1010);
    wr(A_LIVE, 4'b0000);
    wr(A_RSV, 4'b0000);
    rd_chk("R10 mask untouched", A_MSK, 4'b1010);
    rd_chk("R10 sticky untouched", A_STK, 4'b0100);
    rd_chk("R10 reserved reads 0", A_RSV, 4'b0000);
    chk("R8 unmasked bit2 irq", 32'(irq_n_o), 32'd0);
  endtask

  initial begin
    rst_ni = 1'b0;
    step(3);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_pulse_capture();
    t_write_one();
    t_clear();
    t_live_wins();
    t_mask();
    t_stray();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule